// File: doc/BRIEF.md
# Multi-line interrupt arbiter with vectors

This block gathers interrupt requests from up to sixteen serial lines, kept separately for the receive direction and the transmit direction. Each direction holds one pending bit per line and raises a single master request toward the bus whenever any of its bits is set. Per-line set strobes record new events. Per-line clear strobes withdraw them.

When the bus acknowledges one direction, the block finds the lowest-numbered line with a pending bit in that direction. It clears that bit on the same clock edge and registers an interrupt vector for it. Each line owns an 8-byte slot above a base vector. The receive vector sits at the start of the slot and the transmit vector 4 bytes into it. The vector appears one cycle after the acknowledge and holds until the next acknowledge. Bus grant timing and priority against other devices are handled elsewhere.

Top module: `intr_vector_arbiter`

## Requirements
- R1: After reset both pending masks are empty, both master requests are low and the vector output is zero.
- R2: A set strobe on an active line makes that direction's master request high from the next cycle.
- R3: A clear strobe removes a line's pending bit. The master request stays high while any other bit of the same direction is pending, and it falls only when the mask becomes empty.
- R4: On an acknowledge, the lowest-numbered pending line of that direction wins, and its pending bit is cleared on the same clock edge.
- R5: A receive acknowledge produces the vector base + 8 × line, one cycle after the acknowledge.
- R6: A transmit acknowledge produces the vector base + 8 × line + 4, one cycle after the acknowledge.
- R7: An acknowledge when the acknowledged direction has nothing pending produces a vector of zero and changes no pending bit.
- R8: Set and clear strobes on lines numbered NUM_LINES or higher are ignored. Such lines never become pending and never win.
- R9: A set strobe on a line takes priority over a clear strobe, or over an acknowledge clear, of the same line in the same cycle. The line stays pending.
- R10: When both acknowledges arrive in one cycle, the receive direction is served and the transmit acknowledge is ignored. The transmit mask is left unchanged.
- R11: The vector output keeps its value in every cycle without an acknowledge.
- R12: The receive and transmit directions are independent. Strobes on one leave the other's master request and pending bits unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_set | input | 16 | Per-line receive request set strobes |
| rx_clr | input | 16 | Per-line receive request clear strobes |
| tx_set | input | 16 | Per-line transmit request set strobes |
| tx_clr | input | 16 | Per-line transmit request clear strobes |
| rx_ack | input | 1 | Receive interrupt acknowledge strobe |
| tx_ack | input | 1 | Transmit interrupt acknowledge strobe |
| base_vec | input | 16 | Base interrupt vector |
| rx_irq | output | 1 | Master receive request |
| tx_irq | output | 1 | Master transmit request |
| vec_out | output | 16 | Registered interrupt vector |

## Verification
The bench sets several receive lines in one cycle and acknowledges them in turn. A design that picked the highest line, or failed to clear the winner, would return vectors in the wrong order or repeat the same vector. It clears one of two pending lines and expects the request to stay high, which catches a request that simply follows the last strobe. It also checks a set that coincides with a clear or an acknowledge of the same line: a design that let the clear win would lose the event, and the request would fall. Simultaneous acknowledges, an acknowledge with nothing pending and strobes on lines above the active count complete the set. Wrong handling would show up as a lost transmit request, a stale nonzero vector or a phantom request.

// File: rtl/intr_arb_pkg.sv
// Package: shared sizes, the direction type and the active-line mask helper.
// Assumes: no more than MAX_LINES lines are ever configured.
package intr_arb_pkg;

    localparam int MAX_LINES = 16;
    localparam int LINE_W    = $clog2(MAX_LINES);
    localparam int SLOT_SH   = 3;   // each line owns an 8-byte vector slot
    localparam int TX_OFFS   = 4;   // transmit entry sits half-way into the slot

    typedef enum logic [0:0] {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } arb_dir_e;

    // Mask with one bit for each line below n.
    function automatic logic [MAX_LINES-1:0] active_lines(input int n);
        logic [MAX_LINES-1:0] m;
        for (int i = 0; i < MAX_LINES; i++) begin
            m[i] = (i < n);
        end
        return m;
    endfunction

endpackage

// File: rtl/line_pending_mask.sv
// Module: line_pending_mask
// Holds one pending bit per line for one direction.
// A set strobe beats both the clear strobe and the acknowledge clear of the same line.
// Assumes: lines at or above NUM_LINES are not built and read as zero.
module line_pending_mask
    import intr_arb_pkg::*;
#(
    parameter int NUM_LINES = MAX_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_LINES-1:0] set_i,
    input  logic [MAX_LINES-1:0] clr_i,
    input  logic [MAX_LINES-1:0] take_i,
    output logic [MAX_LINES-1:0] pend_o,
    output logic                 any_o
);

    for (genvar g = 0; g < MAX_LINES; g++) begin : g_line
        if (g < NUM_LINES) begin : g_active
            // Purpose: update this line's pending bit, with set taking priority.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_o[g] <= 1'b0;
                end else if (set_i[g]) begin
                    pend_o[g] <= 1'b1;
                end else if (clr_i[g] || take_i[g]) begin
                    pend_o[g] <= 1'b0;
                end
            end
        end else begin : g_idle
            logic unused_strobes;
            assign unused_strobes = set_i[g] ^ clr_i[g] ^ take_i[g];
            assign pend_o[g]      = 1'b0;
        end
    end

    // Purpose: the master request follows the OR of the pending bits.
    assign any_o = |pend_o;

endmodule

// File: rtl/lowest_first_picker.sv
// Module: lowest_first_picker
// Finds the lowest-numbered set bit of a request vector.
// Returns its index and a one-hot mask of it.
// Assumes: purely combinational; the caller registers the results.
module lowest_first_picker
    import intr_arb_pkg::*;
(
    input  logic [MAX_LINES-1:0] req_i,
    output logic                 hit_o,
    output logic [LINE_W-1:0]    idx_o,
    output logic [MAX_LINES-1:0] onehot_o
);

    // Purpose: scan from the top down so the lowest set bit is written last.
    always_comb begin
        hit_o    = 1'b0;
        idx_o    = '0;
        onehot_o = '0;
        for (int i = MAX_LINES - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o    = 1'b1;
                idx_o    = LINE_W'(i);
                onehot_o = '0;
                onehot_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vector_former.sv
// Module: vector_former
// Registers the interrupt vector for a served acknowledge.
// The vector is the base plus the line's slot, plus the transmit offset for the transmit direction.
// It is zero when the acknowledged direction had nothing pending.
// Assumes: VEC_W is wide enough for base plus the largest slot offset.
module vector_former
    import intr_arb_pkg::*;
#(
    parameter int VEC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serve_i,
    input  arb_dir_e          dir_i,
    input  logic              hit_i,
    input  logic [LINE_W-1:0] idx_i,
    input  logic [VEC_W-1:0]  base_i,
    output logic [VEC_W-1:0]  vec_o
);

    logic [VEC_W-1:0] slot_offs;
    logic [VEC_W-1:0] dir_offs;

    // Purpose: byte offset of the winning line's entry.
    always_comb begin
        slot_offs = VEC_W'(idx_i) << SLOT_SH;
        dir_offs  = (dir_i == DIR_TX) ? VEC_W'(TX_OFFS) : '0;
    end

    // Purpose: capture the vector on a served acknowledge and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_o <= '0;
        end else if (serve_i) begin
            vec_o <= hit_i ? (base_i + slot_offs + dir_offs) : '0;
        end
    end

endmodule

// File: rtl/intr_vector_arbiter.sv
// Module: intr_vector_arbiter (top)
// Two pending masks, one for receive and one for transmit, each with a lowest-first picker.
// One vector register is shared by both directions.
// Receive wins when both acknowledges arrive together; the transmit acknowledge is then dropped.
// Assumes: 1 <= NUM_LINES <= 16; the strobes are single-cycle and synchronous to clk.
module intr_vector_arbiter
    import intr_arb_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int VEC_W     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_LINES-1:0] rx_set,
    input  logic [MAX_LINES-1:0] rx_clr,
    input  logic [MAX_LINES-1:0] tx_set,
    input  logic [MAX_LINES-1:0] tx_clr,
    input  logic                 rx_ack,
    input  logic                 tx_ack,
    input  logic [VEC_W-1:0]     base_vec,
    output logic                 rx_irq,
    output logic                 tx_irq,
    output logic [VEC_W-1:0]     vec_out
);

    localparam int EFF_LINES = (NUM_LINES < 1) ? 1 :
                               (NUM_LINES > MAX_LINES) ? MAX_LINES : NUM_LINES;

    logic [MAX_LINES-1:0] rx_pend_q, tx_pend_q;
    logic [MAX_LINES-1:0] rx_win, tx_win;
    logic [MAX_LINES-1:0] rx_take, tx_take;
    logic [LINE_W-1:0]    rx_idx, tx_idx;
    logic                 rx_hit, tx_hit;
    logic                 tx_served;
    logic                 serve;
    arb_dir_e             serve_dir;
    logic                 serve_hit;
    logic [LINE_W-1:0]    serve_idx;

    // Purpose: the transmit acknowledge counts only when receive is not acknowledged in the same cycle.
    always_comb begin
        tx_served = tx_ack && !rx_ack;
        rx_take   = rx_ack    ? rx_win : '0;
        tx_take   = tx_served ? tx_win : '0;
        serve     = rx_ack || tx_ack;
        serve_dir = rx_ack ? DIR_RX : DIR_TX;
        serve_hit = rx_ack ? rx_hit : tx_hit;
        serve_idx = rx_ack ? rx_idx : tx_idx;
    end

    line_pending_mask #(.NUM_LINES(EFF_LINES)) u_rx_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (rx_set),
        .clr_i  (rx_clr),
        .take_i (rx_take),
        .pend_o (rx_pend_q),
        .any_o  (rx_irq)
    );

    line_pending_mask #(.NUM_LINES(EFF_LINES)) u_tx_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (tx_set),
        .clr_i  (tx_clr),
        .take_i (tx_take),
        .pend_o (tx_pend_q),
        .any_o  (tx_irq)
    );

    lowest_first_picker u_rx_pick (
        .req_i    (rx_pend_q),
        .hit_o    (rx_hit),
        .idx_o    (rx_idx),
        .onehot_o (rx_win)
    );

    lowest_first_picker u_tx_pick (
        .req_i    (tx_pend_q),
        .hit_o    (tx_hit),
        .idx_o    (tx_idx),
        .onehot_o (tx_win)
    );

    vector_former #(.VEC_W(VEC_W)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .serve_i (serve),
        .dir_i   (serve_dir),
        .hit_i   (serve_hit),
        .idx_i   (serve_idx),
        .base_i  (base_vec),
        .vec_o   (vec_out)
    );

endmodule

// File: rtl/intr_vector_arbiter_checker.sv
// Module: intr_vector_arbiter_checker
// Temporal properties of the arbiter, attached to the top by bind.
// Assumes: it sees the two pending masks of the top.
module intr_vector_arbiter_checker
    import intr_arb_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int VEC_W     = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MAX_LINES-1:0] rx_set,
    input logic [MAX_LINES-1:0] tx_set,
    input logic [MAX_LINES-1:0] tx_clr,
    input logic                 rx_ack,
    input logic                 tx_ack,
    input logic                 rx_irq,
    input logic [VEC_W-1:0]     vec_out,
    input logic [MAX_LINES-1:0] rx_pend_q,
    input logic [MAX_LINES-1:0] tx_pend_q
);

    localparam logic [MAX_LINES-1:0] ACTIVE = active_lines(NUM_LINES);

    logic [MAX_LINES-1:0] rx_lowest;
    assign rx_lowest = rx_pend_q & (~rx_pend_q + 1'b1);

    AST_SET_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_set & ACTIVE)) |=> rx_irq);   // R2

    AST_ACK_CLEARS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && (|rx_pend_q) && ((rx_set & rx_lowest) == '0))
        |=> ((rx_pend_q & $past(rx_lowest)) == '0));   // R4

    AST_EMPTY_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && (rx_pend_q == '0)) |=> (vec_out == '0));   // R7

    AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_pend_q | tx_pend_q) & ~ACTIVE) == '0);   // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rx_set & ACTIVE)) |=> ((rx_pend_q & $past(rx_set & ACTIVE)) == $past(rx_set & ACTIVE)));   // R9

    AST_DUAL_ACK_TX_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && tx_ack && (tx_set == '0) && (tx_clr == '0)) |=> $stable(tx_pend_q));   // R10

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ack && !tx_ack) |=> $stable(vec_out));   // R11

endmodule

bind intr_vector_arbiter intr_vector_arbiter_checker #(
    .NUM_LINES (NUM_LINES),
    .VEC_W     (VEC_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_set    (rx_set),
    .tx_set    (tx_set),
    .tx_clr    (tx_clr),
    .rx_ack    (rx_ack),
    .tx_ack    (tx_ack),
    .rx_irq    (rx_irq),
    .vec_out   (vec_out),
    .rx_pend_q (rx_pend_q),
    .tx_pend_q (tx_pend_q)
);

// File: tb/test_intr_vector_arbiter.sv
// Directed bench: one task per scenario.
// Inputs are driven on the falling edge and results are checked on the next falling edge.
module test_intr_vector_arbiter;

    localparam int LINES = 12;
    localparam logic [15:0] BASE = 16'h00C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rx_set = '0, rx_clr = '0, tx_set = '0, tx_clr = '0;
    logic        rx_ack = 1'b0, tx_ack = 1'b0;
    logic [15:0] base_vec = BASE;
    logic        rx_irq, tx_irq;
    logic [15:0] vec_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    intr_vector_arbiter #(.NUM_LINES(LINES), .VEC_W(16)) i_intr_vector_arbiter (
        .clk(clk), .rst_n(rst_n),
        .rx_set(rx_set), .rx_clr(rx_clr), .tx_set(tx_set), .tx_clr(tx_clr),
        .rx_ack(rx_ack), .tx_ack(tx_ack), .base_vec(base_vec),
        .rx_irq(rx_irq), .tx_irq(tx_irq), .vec_out(vec_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; returns on the falling edge after the clock edge that sampled it.
    task automatic step(input logic [15:0] rs, input logic [15:0] rc,
                        input logic [15:0] ts, input logic [15:0] tc,
                        input logic ra, input logic ta);
        rx_set = rs; rx_clr = rc; tx_set = ts; tx_clr = tc; rx_ack = ra; tx_ack = ta;
        @(negedge clk);
        rx_set = '0; rx_clr = '0; tx_set = '0; tx_clr = '0; rx_ack = 1'b0; tx_ack = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 rx_irq", 16'(rx_irq), 16'd0);
        check("R1 tx_irq", 16'(tx_irq), 16'd0);
        check("R1 vec", vec_out, 16'd0);
    endtask

    task automatic t_set_and_serve;
        step(16'h0020, '0, '0, '0, 0, 0);
        check("R2 rx_irq after set", 16'(rx_irq), 16'd1);
        check("R12 tx_irq untouched", 16'(tx_irq), 16'd0);
        step('0, '0, '0, '0, 1, 0);
        check("R5 rx vector line5", vec_out, BASE + 16'd40);
        check("R4 winner cleared", 16'(rx_irq), 16'd0);
    endtask

    task automatic t_clear;
        step(16'h0084, '0, '0, '0, 0, 0);
        step('0, 16'h0004, '0, '0, 0, 0);
        check("R3 irq held with bit left", 16'(rx_irq), 16'd1);
        step('0, 16'h0080, '0, '0, 0, 0);
        check("R3 irq drops on empty", 16'(rx_irq), 16'd0);
    endtask

    task automatic t_priority;
        step(16'h0A08, '0, '0, '0, 0, 0);
        step('0, '0, '0, '0, 1, 0);
        check("R4 first winner line3", vec_out, BASE + 16'd24);
        step('0, '0, '0, '0, 1, 0);
        check("R4 second winner line9", vec_out, BASE + 16'd72);
        check("R4 irq still up", 16'(rx_irq), 16'd1);
        step('0, '0, '0, '0, 1, 0);
        check("R4 third winner line11", vec_out, BASE + 16'd88);
        check("R4 irq down", 16'(rx_irq), 16'd0);
        step('0, '0, '0, '0, 1, 0);
        check("R7 empty ack vector", vec_out, 16'd0);
        check("R7 irq still low", 16'(rx_irq), 16'd0);
    endtask

    task automatic t_transmit;
        step('0, '0, 16'h0801, '0, 0, 0);
        check("R2 tx_irq after set", 16'(tx_irq), 16'd1);
        check("R12 rx_irq untouched", 16'(rx_irq), 16'd0);
        step('0, '0, '0, '0, 0, 1);
        check("R6 tx vector line0", vec_out, BASE + 16'd4);
        step('0, '0, '0, '0, 0, 1);
        check("R6 tx vector line11", vec_out, BASE + 16'd92);
        check("R6 tx_irq down", 16'(tx_irq), 16'd0);
    endtask

    task automatic t_inactive;
        step(16'hE000, '0, 16'h1000, '0, 0, 0);
        check("R8 rx_irq ignores high lines", 16'(rx_irq), 16'd0);
        check("R8 tx_irq ignores high lines", 16'(tx_irq), 16'd0);
        step('0, '0, '0, '0, 1, 0);
        check("R8 no high-line vector", vec_out, 16'd0);
    endtask

    task automatic t_set_wins;
        step(16'h0010, 16'h0010, '0, '0, 0, 0);
        check("R9 set beats clear", 16'(rx_irq), 16'd1);
        step(16'h0010, '0, '0, '0, 1, 0);
        check("R9 ack vector line4", vec_out, BASE + 16'd32);
        check("R9 set beats ack clear", 16'(rx_irq), 16'd1);
        step('0, '0, '0, '0, 1, 0);
        check("R9 line4 still pending", vec_out, BASE + 16'd32);
        check("R9 now empty", 16'(rx_irq), 16'd0);
    endtask

    task automatic t_dual_ack;
        step(16'h0002, '0, 16'h0040, '0, 0, 0);
        step('0, '0, '0, '0, 1, 1);
        check("R10 receive served", vec_out, BASE + 16'd8);
        check("R10 rx cleared", 16'(rx_irq), 16'd0);
        check("R10 tx kept", 16'(tx_irq), 16'd1);
        step('0, '0, '0, '0, 0, 1);
        check("R10 tx line6 later", vec_out, BASE + 16'd52);
    endtask

    task automatic t_hold;
        step(16'h0001, '0, '0, '0, 0, 0);
        step('0, '0, '0, '0, 1, 0);
        check("R5 rx vector line0", vec_out, BASE);
        base_vec = 16'h0400;
        repeat (3) step('0, '0, 16'h0004, 16'h0004, 0, 0);
        check("R11 vector held", vec_out, BASE);
        base_vec = BASE;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_and_serve();
        t_clear();
        t_priority();
        t_transmit();
        t_inactive();
        t_set_wins();
        t_dual_ack();
        t_hold();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule